// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block carries out interrupt entry for a small 8-bit processor core. It captures requests from one non-maskable source and eight maskable sources (two external lines, an A/D-complete flag, three timers, a port-change input and a serial unit). Each request is held in a pending bit until that interrupt is serviced, whatever the request line does afterwards.

The core raises a boundary strobe between instructions. When the strobe finds an interrupt that may be taken, the sequencer stores the program counter, index register, accumulator and condition codes on the stack through a byte-wide write port. It then raises a pulse telling the core to set its interrupt mask, reads the 16-bit vector of the winning source and returns the new program counter and stack pointer with a one-cycle done pulse. The whole entry takes 11 cycles. A parameter selects a basic variant that has a single maskable source with one shared vector.

Top module: `irq_entry_seq`

## Requirements
- R1: A rising edge on any request input sets its pending bit. The bit stays set after the input falls and is cleared only when that source is serviced.
- R2: The non-maskable request wins over every maskable one and is taken even while `mask_flag` is 1. Its vector address is 0x1FFC.
- R3: While `mask_flag` is 1, a boundary strobe with only maskable requests pending starts no entry (`busy` stays 0), and those requests remain pending.
- R4: The bits of `irq_req` map as follows: bit 0 IRQ1, bit 1 IRQ2, bit 2 A/D done, bit 3 timer 1, bit 4 timer 2, bit 5 timer 3, bit 6 port change, bit 7 serial. The lower bit index has the higher priority.
- R5: The vector addresses are: bit 0 0x1FF8, bit 1 0x1FEC, bit 2 0x1FEA, bit 3 0x1FF6, bit 4 0x1FF4, bit 5 0x1FF2, bit 6 0x1FF0, bit 7 0x1FEE.
- R6: Take the clock edge that samples the strobe as the decision edge. In cycles 1 to 5 after it, `mem_we` is 1 with writes to SP, SP-1, SP-2, SP-3 and SP-4. The bytes written are, in that order, PC[7:0], PC[15:8], X, A and CC.
- R7: In cycle 6, `mask_set` pulses for one cycle, and no write occurs from then on. The returned stack pointer is SP-5.
- R8: The block reads the vector with `mem_re` at the vector address in cycle 7 and at the vector address plus 1 in cycle 8. Read data is expected one cycle after the read. In cycle 11, `done` is 1 for one cycle and `new_pc` is {byte at vector, byte at vector+1}.
- R9: An entry clears only the serviced source's pending bit. Other pending sources are taken on later strobes in priority order.
- R10: The block makes a decision only on a boundary strobe while it is idle. Strobes during an entry are ignored, and requests that arrive during an entry are latched and serviced afterwards.
- R11: With `EXTENDED` = 0, only `irq_req` bit 0 is a maskable source, and its vector address is 0xFFFA. The other bits never start an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request, captured on its rising edge |
| irq_req | input | 8 | Maskable requests, captured on rising edges (bit map in R4) |
| mask_flag | input | 1 | Interrupt mask bit of the core's condition codes |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| cpu_pc | input | 16 | Program counter to be stacked |
| cpu_x | input | 8 | Index register to be stacked |
| cpu_a | input | 8 | Accumulator to be stacked |
| cpu_cc | input | 8 | Condition codes to be stacked |
| cpu_sp | input | 16 | Current stack pointer |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| mem_we | output | 1 | Stack byte write strobe |
| mem_re | output | 1 | Vector byte read strobe |
| mem_addr | output | 16 | Memory address for write or read |
| mem_wdata | output | 8 | Byte to write |
| busy | output | 1 | Entry in progress (cycles 1 to 11) |
| mask_set | output | 1 | One-cycle request to the core to set its mask flag |
| done | output | 1 | One-cycle pulse: `new_pc` and `new_sp` are valid |
| new_pc | output | 16 | Program counter loaded from the vector |
| new_sp | output | 16 | Stack pointer after stacking |

## Verification
Each result is tied to a fixed cycle after the decision edge. Stack writes fall in cycles 1 to 5, the mask pulse in cycle 6, the vector reads in cycles 7 and 8, and `done` with the new program counter in cycle 11. A strobe that must be refused is checked by `busy` staying low one cycle after it. The bench drives inputs and samples outputs on the falling edge and counts the cycles itself, checking every output value in each of those cycles. The memory model returns read data one cycle after a read, so a vector byte captured one cycle late or early shows up as a wrong `new_pc`.

// File: rtl/irq_entry_pkg.sv
// Shared constants and types of the interrupt entry sequencer.
// Assumes a 16-bit address space and byte-wide memory.
package irq_entry_pkg;
    localparam int NSRC   = 8;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] VEC_NMI   = 16'h1FFC;
    localparam logic [ADDR_W-1:0] VEC_BASIC = 16'hFFFA;

    // entry steps; the value of each step equals its cycle number after the decision edge
    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_PCL   = 4'd1,
        ST_PCH   = 4'd2,
        ST_X     = 4'd3,
        ST_A     = 4'd4,
        ST_CC    = 4'd5,
        ST_MASK  = 4'd6,
        ST_RDHI  = 4'd7,
        ST_RDLO  = 4'd8,
        ST_CAPLO = 4'd9,
        ST_WAIT  = 4'd10,
        ST_DONE  = 4'd11
    } step_e;

    // vector address of maskable source idx (0 = highest priority)
    function automatic logic [ADDR_W-1:0] src_vector(input int idx);
        logic [ADDR_W-1:0] v;
        case (idx)
            0:       v = 16'h1FF8;
            1:       v = 16'h1FEC;
            2:       v = 16'h1FEA;
            3:       v = 16'h1FF6;
            4:       v = 16'h1FF4;
            5:       v = 16'h1FF2;
            6:       v = 16'h1FF0;
            default: v = 16'h1FEE;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/irq_pending.sv
// Edge-capture pending register: a rising edge on req[i] sets pend[i],
// which stays set until clr[i] is pulsed. A set in the same cycle as a
// clear wins, so no edge is lost.
module irq_pending #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] prev_q;
    logic [N-1:0] pend_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            // capture a rising edge of one request line and hold it until serviced
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q[i] <= 1'b0;
                    pend_q[i] <= 1'b0;
                end else begin
                    prev_q[i] <= req[i];
                    pend_q[i] <= (pend_q[i] & ~clr[i]) | (req[i] & ~prev_q[i]);
                end
            end
        end
    endgenerate

    assign pend = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
// Fixed-priority arbiter: the non-maskable source first, then the maskable
// sources by ascending index while the mask is clear. Produces a one-hot
// grant (bit N = non-maskable) and the vector address of the winner.
// With EXTENDED = 0 only maskable bit 0 is eligible, and it uses VEC_BASIC.
module irq_arbiter
    import irq_entry_pkg::*;
#(
    parameter int N        = NSRC,
    parameter bit EXTENDED = 1'b1
) (
    input  logic              nmi_pend,
    input  logic [N-1:0]      pend,
    input  logic              mask_flag,
    output logic              take_ok,
    output logic [N:0]        grant,
    output logic [ADDR_W-1:0] vector
);
    localparam logic [N-1:0] ELIG_MASK = EXTENDED ? {N{1'b1}} : {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] elig;

    // sources that may be taken right now
    always_comb elig = mask_flag ? '0 : (pend & ELIG_MASK);

    // pick the highest-priority eligible source and its vector
    always_comb begin
        grant  = '0;
        vector = VEC_NMI;
        if (nmi_pend) begin
            grant[N] = 1'b1;
        end else begin
            for (int i = N - 1; i >= 0; i--) begin
                if (elig[i]) begin
                    grant     = '0;
                    grant[i]  = 1'b1;
                    vector    = EXTENDED ? src_vector(i) : VEC_BASIC;
                end
            end
        end
    end

    // an entry may start when anything is granted
    always_comb take_ok = nmi_pend | (|elig);
endmodule

// File: rtl/irq_entry_fsm.sv
// Eleven-cycle entry sequencer. At a decision edge it captures the core
// context, the winner and its vector. It then writes five stack bytes,
// pulses the mask request, reads the two vector bytes and reports the
// result. It assumes memory read data arrives one cycle after mem_re.
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              take_ok,
    input  logic [N:0]        grant,
    input  logic [ADDR_W-1:0] vector,
    input  logic [ADDR_W-1:0] cpu_pc,
    input  logic [DATA_W-1:0] cpu_x,
    input  logic [DATA_W-1:0] cpu_a,
    input  logic [DATA_W-1:0] cpu_cc,
    input  logic [ADDR_W-1:0] cpu_sp,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              start,
    output logic [N:0]        clr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              mask_set,
    output logic              done,
    output logic [ADDR_W-1:0] new_pc,
    output logic [ADDR_W-1:0] new_sp
);
    step_e             step_q;
    logic [ADDR_W-1:0] pc_q, sp_q, vec_q;
    logic [DATA_W-1:0] x_q, a_q, cc_q, hi_q, lo_q;

    // decision: only at a strobe while idle
    always_comb start = boundary && (step_q == ST_IDLE) && take_ok;
    // clear only the serviced source
    always_comb clr = start ? grant : '0;

    // step counter through the entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
        end else begin
            case (step_q)
                ST_IDLE: if (start) step_q <= ST_PCL;
                ST_DONE: step_q <= ST_IDLE;
                default: step_q <= step_e'(step_q + 4'd1);
            endcase
        end
    end

    // context and vector capture at the decision edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            sp_q  <= '0;
            vec_q <= '0;
            x_q   <= '0;
            a_q   <= '0;
            cc_q  <= '0;
        end else if (start) begin
            pc_q  <= cpu_pc;
            sp_q  <= cpu_sp;
            vec_q <= vector;
            x_q   <= cpu_x;
            a_q   <= cpu_a;
            cc_q  <= cpu_cc;
        end
    end

    // vector byte capture, one cycle after each read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (step_q == ST_RDLO)  hi_q <= mem_rdata;
            if (step_q == ST_CAPLO) lo_q <= mem_rdata;
        end
    end

    // memory strobes, address and data for each step
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (step_q)
            ST_PCL:  begin mem_we = 1'b1; mem_addr = sp_q;                mem_wdata = pc_q[DATA_W-1:0];       end
            ST_PCH:  begin mem_we = 1'b1; mem_addr = sp_q - ADDR_W'(1);   mem_wdata = pc_q[ADDR_W-1:DATA_W];  end
            ST_X:    begin mem_we = 1'b1; mem_addr = sp_q - ADDR_W'(2);   mem_wdata = x_q;                    end
            ST_A:    begin mem_we = 1'b1; mem_addr = sp_q - ADDR_W'(3);   mem_wdata = a_q;                    end
            ST_CC:   begin mem_we = 1'b1; mem_addr = sp_q - ADDR_W'(4);   mem_wdata = cc_q;                   end
            ST_RDHI: begin mem_re = 1'b1; mem_addr = vec_q;                                                   end
            ST_RDLO: begin mem_re = 1'b1; mem_addr = vec_q + ADDR_W'(1);                                      end
            default: ;
        endcase
    end

    // handshake outputs to the core
    always_comb begin
        busy     = (step_q != ST_IDLE);
        mask_set = (step_q == ST_MASK);
        done     = (step_q == ST_DONE);
        new_pc   = {hi_q, lo_q};
        new_sp   = sp_q - ADDR_W'(5);
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Top of the interrupt entry sequencer: pending capture for the
// non-maskable and maskable requests, the priority arbiter and the entry
// step sequencer. EXTENDED selects eight maskable sources (1) or a single
// one (0).
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_req,
    input  logic [NSRC-1:0]   irq_req,
    input  logic              mask_flag,
    input  logic              boundary,
    input  logic [ADDR_W-1:0] cpu_pc,
    input  logic [DATA_W-1:0] cpu_x,
    input  logic [DATA_W-1:0] cpu_a,
    input  logic [DATA_W-1:0] cpu_cc,
    input  logic [ADDR_W-1:0] cpu_sp,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              mask_set,
    output logic              done,
    output logic [ADDR_W-1:0] new_pc,
    output logic [ADDR_W-1:0] new_sp
);
    logic [NSRC-1:0]   pend_w;
    logic              nmi_pend_w;
    logic [NSRC:0]     clr_w;
    logic [NSRC:0]     grant_w;
    logic [ADDR_W-1:0] vector_w;
    logic              take_ok_w;
    logic              start_w;

    irq_pending #(.N(NSRC)) u_mpend (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (irq_req),
        .clr  (clr_w[NSRC-1:0]),
        .pend (pend_w)
    );

    irq_pending #(.N(1)) u_npend (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (nmi_req),
        .clr  (clr_w[NSRC]),
        .pend (nmi_pend_w)
    );

    irq_arbiter #(.N(NSRC), .EXTENDED(EXTENDED)) u_arb (
        .nmi_pend (nmi_pend_w),
        .pend     (pend_w),
        .mask_flag(mask_flag),
        .take_ok  (take_ok_w),
        .grant    (grant_w),
        .vector   (vector_w)
    );

    irq_entry_fsm #(.N(NSRC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .take_ok  (take_ok_w),
        .grant    (grant_w),
        .vector   (vector_w),
        .cpu_pc   (cpu_pc),
        .cpu_x    (cpu_x),
        .cpu_a    (cpu_a),
        .cpu_cc   (cpu_cc),
        .cpu_sp   (cpu_sp),
        .mem_rdata(mem_rdata),
        .start    (start_w),
        .clr      (clr_w),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .busy     (busy),
        .mask_set (mask_set),
        .done     (done),
        .new_pc   (new_pc),
        .new_sp   (new_sp)
    );
endmodule

// File: rtl/irq_entry_chk.sv
// Temporal checks for the interrupt entry sequencer, bound to the top.
// They observe the top's ports together with its pending and start nets.
module irq_entry_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         done,
    input logic         mem_we,
    input logic         mem_re,
    input logic         mask_set,
    input logic         boundary,
    input logic         start,
    input logic [N-1:0] pend
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_ENDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R8
    AST_WRITE_IN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy && !mem_re)); // R6
    AST_MASK_AFTER_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set |-> ($past(mem_we) && !mem_we)); // R7
    AST_NO_START_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !boundary) |=> !busy); // R10
    AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ((pend & $past(pend)) == $past(pend))); // R1
    AST_ONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ($countones($past(pend) & ~pend) <= 1)); // R9
endmodule

bind irq_entry_seq irq_entry_chk #(.N(irq_entry_pkg::NSRC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .mem_we  (mem_we),
    .mem_re  (mem_re),
    .mask_set(mask_set),
    .boundary(boundary),
    .start   (start_w),
    .pend    (pend_w)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 1'b0;
    logic [7:0]  irq_req = 8'h00;
    logic        mask_flag = 1'b0;
    logic        boundary = 1'b0;
    logic [15:0] cpu_pc = 16'hA000;
    logic [7:0]  cpu_x = 8'h11, cpu_a = 8'h22, cpu_cc = 8'h03;
    logic [15:0] cpu_sp = 16'h00FF;
    logic [7:0]  rdata = 8'h00, b_rdata = 8'h00;
    logic        mem_we, mem_re, busy, mask_set, done;
    logic [15:0] mem_addr, new_pc, new_sp;
    logic [7:0]  mem_wdata;
    logic        b_we, b_re, b_busy, b_mask_set, b_done;
    logic [15:0] b_addr, b_new_pc, b_new_sp;
    logic [7:0]  b_wdata;
    int n_checks = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    irq_entry_seq #(.EXTENDED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
        .mask_flag(mask_flag), .boundary(boundary), .cpu_pc(cpu_pc),
        .cpu_x(cpu_x), .cpu_a(cpu_a), .cpu_cc(cpu_cc), .cpu_sp(cpu_sp),
        .mem_rdata(rdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
        .mask_set(mask_set), .done(done), .new_pc(new_pc), .new_sp(new_sp));

    irq_entry_seq #(.EXTENDED(1'b0)) dut_basic (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
        .mask_flag(mask_flag), .boundary(boundary), .cpu_pc(cpu_pc),
        .cpu_x(cpu_x), .cpu_a(cpu_a), .cpu_cc(cpu_cc), .cpu_sp(cpu_sp),
        .mem_rdata(b_rdata), .mem_we(b_we), .mem_re(b_re),
        .mem_addr(b_addr), .mem_wdata(b_wdata), .busy(b_busy),
        .mask_set(b_mask_set), .done(b_done), .new_pc(b_new_pc), .new_sp(b_new_sp));

    // memory contents as a function of address
    function automatic logic [7:0] rom(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // read data one cycle after a read strobe
    always @(posedge clk) begin
        rdata   <= mem_re ? rom(mem_addr) : 8'h00;
        b_rdata <= b_re ? rom(b_addr) : 8'h00;
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; boundary = 1'b0; irq_req = 8'h00; nmi_req = 1'b0; mask_flag = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_we && !mem_re && !mask_set, "reset",
            {busy, done, mem_we, mem_re, mask_set}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input logic nmi, input logic [7:0] req);
        @(negedge clk); nmi_req = nmi; irq_req = req;
        @(negedge clk); nmi_req = 1'b0; irq_req = 8'h00;
    endtask

    // one full entry expected, checked cycle by cycle after the decision edge
    task automatic do_entry(input logic [15:0] vec, input string rq, input bit hold_bnd, input logic [7:0] mid);
        logic [7:0] expd;
        @(negedge clk); boundary = 1'b1;
        @(posedge clk);
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            chk(busy == 1'b1, {rq, " R10 busy"}, busy, 1);
            chk(done == (k == 11), {rq, " R8 done timing"}, done, (k == 11));
            if (k <= 5) begin
                case (k)
                    1: expd = cpu_pc[7:0];
                    2: expd = cpu_pc[15:8];
                    3: expd = cpu_x;
                    4: expd = cpu_a;
                    default: expd = cpu_cc;
                endcase
                chk(mem_we && mem_addr == cpu_sp - 16'(k - 1) && mem_wdata == expd,
                    {rq, " R6 stack write"}, {7'd0, mem_we, mem_addr, mem_wdata}, {8'd1, cpu_sp - 16'(k - 1), expd});
            end else begin
                chk(!mem_we, {rq, " R7 no write"}, mem_we, 0);
            end
            chk(mask_set == (k == 6), {rq, " R7 mask pulse"}, mask_set, (k == 6));
            if (k == 7) chk(mem_re && mem_addr == vec, {rq, " R5 vector read hi"}, {mem_re, mem_addr}, {1'b1, vec});
            if (k == 8) chk(mem_re && mem_addr == vec + 16'd1, {rq, " R8 vector read lo"}, {mem_re, mem_addr}, {1'b1, vec + 16'd1});
            if (k == 11) begin
                chk(new_pc == {rom(vec), rom(vec + 16'd1)}, {rq, " R8 new pc"}, new_pc, {rom(vec), rom(vec + 16'd1)});
                chk(new_sp == cpu_sp - 16'd5, {rq, " R7 new sp"}, new_sp, cpu_sp - 16'd5);
            end
            boundary = hold_bnd && (k < 4);
            irq_req  = (k == 2) ? mid : 8'h00;
        end
        @(negedge clk);
        chk(!busy && !done, {rq, " R10 idle after"}, {busy, done}, 0);
    endtask

    task automatic expect_idle(input string rq);
        @(negedge clk); boundary = 1'b1;
        @(negedge clk); boundary = 1'b0;
        chk(!busy && !mem_we, rq, {busy, mem_we}, 0);
    endtask

    task automatic drain();
        mask_flag = 1'b0;
        repeat (10) begin
            @(negedge clk); boundary = 1'b1;
            @(negedge clk); boundary = 1'b0;
            while (busy) @(negedge clk);
        end
    endtask

    // rows: [25] nmi, [24] mask, [23:16] requests, [15:0] expected vector
    localparam logic [25:0] ROWS [12] = '{
        {1'b0, 1'b0, 8'h01, 16'h1FF8},
        {1'b0, 1'b0, 8'h02, 16'h1FEC},
        {1'b0, 1'b0, 8'h04, 16'h1FEA},
        {1'b0, 1'b0, 8'h08, 16'h1FF6},
        {1'b0, 1'b0, 8'h10, 16'h1FF4},
        {1'b0, 1'b0, 8'h20, 16'h1FF2},
        {1'b0, 1'b0, 8'h40, 16'h1FF0},
        {1'b0, 1'b0, 8'h80, 16'h1FEE},
        {1'b1, 1'b1, 8'h00, 16'h1FFC},
        {1'b1, 1'b0, 8'hFF, 16'h1FFC},
        {1'b0, 1'b0, 8'h0C, 16'h1FEA},
        {1'b0, 1'b0, 8'h84, 16'h1FEA}
    };

    initial begin
        #(8 * 100000);
        n_err++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        do_reset();

        // R1 R4 R5 R2: table walk, requests pulsed and released before the strobe
        for (int i = 0; i < 12; i++) begin
            cpu_pc = 16'hA000 + 16'(i) * 16'h0101;
            pulse(ROWS[i][25], ROWS[i][23:16]);
            repeat (2) @(negedge clk);
            mask_flag = ROWS[i][24];
            do_entry(ROWS[i][15:0], $sformatf("R4 row%0d", i), 1'b0, 8'h00);
            drain();
        end

        // R3: masked request refused, then taken once unmasked
        mask_flag = 1'b1;
        pulse(1'b0, 8'h02);
        expect_idle("R3 masked refused");
        mask_flag = 1'b0;
        do_entry(16'h1FEC, "R3 taken after unmask", 1'b0, 8'h00);
        expect_idle("R3 nothing left");

        // R9: only the serviced bit is cleared, the rest follow in priority order
        pulse(1'b0, 8'h51);
        do_entry(16'h1FF8, "R9 first", 1'b0, 8'h00);
        do_entry(16'h1FF4, "R9 second", 1'b0, 8'h00);
        do_entry(16'h1FF0, "R9 third", 1'b0, 8'h00);
        expect_idle("R9 all serviced");

        // R10: strobes during entry ignored; request arriving mid-entry serviced next
        pulse(1'b0, 8'h08);
        do_entry(16'h1FF6, "R10 hold strobe", 1'b1, 8'h20);
        do_entry(16'h1FF2, "R10 late request", 1'b0, 8'h00);
        expect_idle("R10 none pending");

        // R11: basic variant ignores bits 1..7 and uses 0xFFFA for bit 0
        do_reset();
        pulse(1'b0, 8'hFE);
        @(negedge clk); boundary = 1'b1;
        @(negedge clk); boundary = 1'b0;
        chk(!b_busy, "R11 upper bits ignored", b_busy, 0);
        while (busy) @(negedge clk);
        pulse(1'b0, 8'h01);
        @(negedge clk); boundary = 1'b1;
        @(posedge clk);
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            boundary = 1'b0;
            chk(b_done == (k == 11), "R11 done timing", b_done, (k == 11));
            if (k == 7) chk(b_re && b_addr == 16'hFFFA, "R11 vector addr", b_addr, 16'hFFFA);
            if (k == 11) chk(b_new_pc == {rom(16'hFFFA), rom(16'hFFFB)}, "R11 new pc",
                             b_new_pc, {rom(16'hFFFA), rom(16'hFFFB)});
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule